// File: doc/BRIEF.md
# Exponent-Mantissa Baud Rate Generator

This block derives a 16x oversampling tick from a fixed reference clock. The divide ratio is the product of a 6-bit mantissa plus one and a power of two chosen by a 4-bit exponent, so one tick is produced every (N+1)·2^M reference cycles. A bit-rate strobe marks every sixteenth tick. A receiver uses the 16x tick for mid-bit sampling, and a transmitter uses the strobe to shift bits out. With a 29.4912 MHz reference, the tick rate is the reference divided by the ratio, and the bit rate is that tick rate divided by 16.

The 10-bit divisor is packed with the mantissa in bits [5:0] and the exponent in bits [9:6]. It is supplied through two byte-wide registers:

- **Low byte register:** holds divisor bits [7:0].
- **Shared control byte:** divisor bits [9:8] sit in bits [7:6] of this byte. A dedicated field write updates those two bits and leaves the other six untouched.

A written divisor is staged. It becomes active only when the current tick period ends, so no short period is ever produced. A packed divisor of zero disables the generator.

Top module: `em_baud_gen`

## Requirements
- R1: With an active packed divisor holding N in bits [5:0] and M in bits [9:6], consecutive rises of tick_o are exactly (N+1)·2^M clock cycles apart.
- R2: tick_o is high for a single clock cycle per tick.
- R3: bit_o is high together with every sixteenth tick and at no other time, so consecutive strobes are 16·(N+1)·2^M cycles apart.
- R4: A write to address 0 sets staged divisor bits [7:0] to the write data.
- R5: A write to address 1 replaces the whole control byte. Control bits [7:6] are divisor bits [9:8].
- R6: A write to address 2 copies data bits [7:6] into control bits [7:6] and leaves control bits [5:0] unchanged.
- R7: A write to address 3 changes neither the control byte nor the divisor.
- R8: A staged divisor becomes active, and visible on div_o, only at the end of a tick period. The period running when the write occurs completes at its old length.
- R9: An active divisor of zero produces no ticks and clears the tick-in-bit count. A nonzero staged value written while disabled becomes active on the next cycle, and its first strobe comes on the sixteenth tick.
- R10: After reset, tick_o, bit_o, div_o and ctrl_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | 0 low divisor byte, 1 control byte, 2 divisor high field, 3 unused |
| reg_wdata_i | input | 8 | Write data |
| tick_o | output | 1 | 16x oversampling tick, one cycle wide |
| bit_o | output | 1 | Bit-rate strobe, on every sixteenth tick |
| div_o | output | 10 | Active packed divisor |
| ctrl_o | output | 8 | Control byte contents |

## Verification
The bench builds the block with its default parameters: a 6-bit mantissa, a 4-bit exponent and 16 ticks per bit. With these values both extremes can be measured within the run: N=63 gives a 64-cycle period, and M=15 gives a 32768-cycle period. Tick spacing is also measured for mid-range pairs and across a divisor change made during a period. At a 2-cycle period, 16-tick strobe spacing can be observed in a few dozen cycles, and the disable-and-restart path can be exercised without long waits.

// File: rtl/em_baud_pkg.sv
package em_baud_pkg;
  typedef enum logic [1:0] {
    ADDR_DIV_LO = 2'd0,
    ADDR_CTRL   = 2'd1,
    ADDR_DIV_HI = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/em_baud_regs.sv
module em_baud_regs #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       ctrl_o,
  output logic [DIV_W-1:0] stg_div_o
);
  import em_baud_pkg::*;
  localparam int unsigned HI_W = DIV_W - 8;

  logic [7:0] lo_q;
  logic [7:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        ADDR_DIV_LO: lo_q <= wdata_i;
        ADDR_CTRL:   ctrl_q <= wdata_i;
        ADDR_DIV_HI: ctrl_q[7 -: HI_W] <= wdata_i[7 -: HI_W];
        default:     ;
      endcase
    end
  end

  assign ctrl_o    = ctrl_q;
  assign stg_div_o = {ctrl_q[7 -: HI_W], lo_q};
endmodule

// File: rtl/em_baud_core.sv
module em_baud_core #(
  parameter int unsigned MANT_W = 6,
  parameter int unsigned EXP_W  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [MANT_W+EXP_W-1:0]   stg_div_i,
  output logic [MANT_W+EXP_W-1:0]   act_div_o,
  output logic                      run_o,
  output logic                      term_o,
  output logic                      tick_o
);
  localparam int unsigned DIV_W = MANT_W + EXP_W;
  localparam int unsigned PRE_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0]  act_q;
  logic [PRE_W-1:0]  pre_q;
  logic [MANT_W-1:0] man_q;
  logic              tick_q;
  logic [EXP_W-1:0]  act_exp;
  logic [PRE_W-1:0]  pre_lim;
  logic              pre_wrap;

  assign act_exp  = act_q[DIV_W-1:MANT_W];
  assign pre_lim  = ~({PRE_W{1'b1}} << act_exp);
  assign run_o    = |act_q;
  assign pre_wrap = (pre_q == pre_lim);
  assign term_o   = run_o && pre_wrap && (man_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pre_q  <= '0;
      man_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (!run_o) begin
        // idle: pick up any nonzero staged value at once
        pre_q <= '0;
        if (|stg_div_i) begin
          act_q <= stg_div_i;
          man_q <= stg_div_i[MANT_W-1:0];
        end
      end else if (pre_wrap) begin
        pre_q <= '0;
        if (man_q == '0) begin
          tick_q <= 1'b1;
          act_q  <= stg_div_i;
          man_q  <= stg_div_i[MANT_W-1:0];
        end else begin
          man_q <= man_q - 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign act_div_o = act_q;
  assign tick_o    = tick_q;
endmodule

// File: rtl/em_baud_ovs.sv
module em_baud_ovs #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic term_i,
  output logic bit_o
);
  localparam int unsigned OVS_W = $clog2(OVS);

  logic [OVS_W-1:0] ovs_q;
  logic             bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovs_q <= '0;
      bit_q <= 1'b0;
    end else if (!run_i) begin
      ovs_q <= '0;
      bit_q <= 1'b0;
    end else if (term_i) begin
      bit_q <= (ovs_q == OVS_W'(OVS - 1));
      ovs_q <= (ovs_q == OVS_W'(OVS - 1)) ? '0 : ovs_q + 1'b1;
    end else begin
      bit_q <= 1'b0;
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/em_baud_gen.sv
module em_baud_gen #(
  parameter int unsigned MANT_W = 6,
  parameter int unsigned EXP_W  = 4,
  parameter int unsigned OVS    = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [7:0]              reg_wdata_i,
  output logic                    tick_o,
  output logic                    bit_o,
  output logic [MANT_W+EXP_W-1:0] div_o,
  output logic [7:0]              ctrl_o
);
  localparam int unsigned DIV_W = MANT_W + EXP_W;

  logic [DIV_W-1:0] stg_div;
  logic             run;
  logic             term;

  em_baud_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .ctrl_o    (ctrl_o),
    .stg_div_o (stg_div)
  );

  em_baud_core #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stg_div_i (stg_div),
    .act_div_o (div_o),
    .run_o     (run),
    .term_o    (term),
    .tick_o    (tick_o)
  );

  em_baud_ovs #(.OVS(OVS)) u_ovs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .term_i (term),
    .bit_o  (bit_o)
  );
endmodule

// File: rtl/em_baud_gen_chk.sv
module em_baud_gen_chk #(
  parameter int unsigned DIV_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic             tick_o,
  input logic             bit_o,
  input logic [DIV_W-1:0] div_o,
  input logic [7:0]       ctrl_o
);
  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2

  AST_BIT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> tick_o); // R3

  AST_CTRL_LOW_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd2) |=> (ctrl_o[5:0] == $past(ctrl_o[5:0]))); // R6

  AST_RSVD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd3) |=> $stable(ctrl_o)); // R7

  AST_RELOAD_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(div_o) != '0) && (div_o != $past(div_o))) |-> tick_o); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(div_o) == '0) |-> !tick_o); // R9
endmodule

bind em_baud_gen em_baud_gen_chk #(.DIV_W(MANT_W + EXP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .tick_o     (tick_o),
  .bit_o      (bit_o),
  .div_o      (div_o),
  .ctrl_o     (ctrl_o)
);

// File: tb/em_baud_gen_tb.sv
module em_baud_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       tick, bitstb;
  logic [9:0] div;
  logic [7:0] ctrl;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  int bexp_q[$];
  int cnt = 0, bcnt = 0, tick_total = 0;
  event tick_ev, bit_ev;

  always #5 clk = ~clk;

  em_baud_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .tick_o(tick), .bit_o(bitstb), .div_o(div), .ctrl_o(ctrl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_div(input int n, input int m, input bit sync);
    logic [3:0] mb;
    mb = 4'(m);
    if (sync) @(tick_ev);
    wr(2'd0, {mb[1:0], 6'(n)});
    wr(2'd2, {mb[3:2], 6'b0});
    @(tick_ev);
  endtask

  // monitor: interval scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cnt++;
      bcnt++;
      if (tick) begin
        tick_total++;
        if (exp_q.size() > 0) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cnt == e, t, cnt, e);
        end
        cnt = 0;
        ->tick_ev;
      end
      if (bitstb) begin
        chk(tick, "R3 strobe with tick", int'(tick), 1);
        if (bexp_q.size() > 0) begin
          int be;
          be = bexp_q.pop_front();
          chk(bcnt == be, "R3 strobe spacing", bcnt, be);
        end
        bcnt = 0;
        ->bit_ev;
      end
    end
  end

  task automatic push(input int p, input string t);
    exp_q.push_back(p);
    tag_q.push_back(t);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tick == 0, "R10 tick", int'(tick), 0);
    chk(bitstb == 0, "R10 bit", int'(bitstb), 0);
    chk(div == 0, "R10 div", int'(div), 0);
    chk(ctrl == 0, "R10 ctrl", int'(ctrl), 0);

    // register fields
    wr(2'd1, 8'hA5);
    chk(ctrl == 8'hA5, "R5 ctrl byte", int'(ctrl), 8'hA5);
    @(negedge clk);
    chk(div == 10'h200, "R5 hi bits into divisor", int'(div), 10'h200);
    wr(2'd2, 8'h3F);
    chk(ctrl == 8'h25, "R6 field write", int'(ctrl), 8'h25);
    chk(div == 10'h200, "R8 no mid-period reload", int'(div), 10'h200);
    wr(2'd3, 8'hFF);
    chk(ctrl == 8'h25, "R7 reserved ctrl", int'(ctrl), 8'h25);
    chk(div == 10'h200, "R7 reserved div", int'(div), 10'h200);
    wr(2'd0, 8'h5A);
    repeat (300) @(negedge clk);
    chk(div == 10'h05A, "R4 low byte reload", int'(div), 10'h05A);

    // spacing for several pairs
    set_div(7, 0, 1);  push(8, "R1 N7M0");     push(8, "R1 N7M0");
    set_div(63, 0, 1); push(64, "R1 N63M0");   push(64, "R1 N63M0");
    set_div(2, 3, 1);  push(24, "R1 N2M3");    push(24, "R1 N2M3");
    set_div(63, 3, 1); push(512, "R1 N63M3");
    // change during a period
    @(tick_ev);
    push(512, "R8 old period completes");
    push(40, "R8 new period");
    repeat (100) @(negedge clk);
    wr(2'd0, 8'hC4);
    wr(2'd2, 8'h00);
    chk(div == 10'h0FF, "R8 div held mid-period", int'(div), 10'h0FF);
    set_div(0, 15, 1); push(32768, "R1 N0M15");
    set_div(0, 1, 1);
    @(bit_ev);
    bexp_q.push_back(32);
    bexp_q.push_back(32);
    push(2, "R1 N0M1");
    wait (bexp_q.size() == 0);

    // disable and restart
    wr(2'd0, 8'h00);
    repeat (10) @(negedge clk);
    chk(div == 0, "R9 disabled div", int'(div), 0);
    t0 = tick_total;
    repeat (200) @(negedge clk);
    chk(tick_total == t0, "R9 no ticks when disabled", tick_total - t0, 0);
    t0 = tick_total;
    wr(2'd0, 8'h40);
    @(negedge clk);
    chk(div == 10'h040, "R9 immediate load", int'(div), 10'h040);
    @(bit_ev);
    chk(tick_total - t0 == 16, "R9 first strobe on tick 16", tick_total - t0, 16);

    wait (exp_q.size() == 0);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule